// File: doc/BRIEF.md
# E1 Receive Multiframe Descriptor Engine

This block is the storage side of one E1 receive channel. Aligned line octets arrive as a strobe-qualified byte stream, together with a multiframe boundary marker, an alignment level and CRC verdicts for each half of the multiframe. The engine writes these octets into a shared data RAM, one whole multiframe per buffer descriptor. Line decoding and the alignment search happen upstream and are modelled here as inputs.

Software hands the engine free multiframe slots by writing slot indices into a small input queue. For each multiframe the engine takes one slot and stores 16 frames of 32 timeslots into that slot's region of the RAM. It then appends a completed descriptor to an output queue. That descriptor carries a valid mark and two CRC-OK bits. Software drains the output queue by reading the descriptor port. A control/status register holds the enable and the reception mode, shows the occupancy flags of both queues and the alignment input, and keeps a sticky overflow flag that software clears with a write-one bit.

Frame and timeslot positions come from counting octets from the start of a fill. The RAM byte address is the slot index, then the frame number, then the timeslot, packed from the most significant bit down.

Top module: `e1_rx_desc_engine`

## Requirements
- R1: After reset the engine is disabled, both queues are empty, overflow is clear and the descriptor port reads 0. The status word reads 0x0500, with bit 1 following the alignment input. Bit 0 of the status word reports the enable written to control bit 0.
- R2: A write to the descriptor port queues its 7-bit slot index. Each queue holds 4 entries, and a write to a full input queue is ignored. Status bits 8, 9, 10 and 11 report input-empty, input-full, output-empty and output-full.
- R3: In mode 3 (control bits 2:1 = 3, multiframe-aligned), a fill starts only on a valid octet that is marked as a multiframe start while the alignment input is high. Octets before that point are not written.
- R4: The k-th octet of a fill (k from 0) is written one cycle after it is accepted, to address (slot << 9) | k. Here k = frame*32 + timeslot.
- R5: After the 512th octet, the descriptor {bit 15 = 1, bit 14 = CRC-OK of the second half, bit 13 = CRC-OK of the first half, bits 6:0 = slot} joins the output queue. Reading the port returns the oldest descriptor and pops it. When the queue is empty the port reads 0, so bit 15 is clear.
- R6: A CRC verdict (crcValid with crcSub selecting the half, crcOk the result) sets that half's bit to crcOk. Both bits are cleared when a fill starts, so a half with no verdict reports 0.
- R7: A fill start while the input queue is empty sets the sticky overflow flag (status bit 12) and consumes no slot. While the flag is set, no octet is written and no fill starts. Writing control bit 12 as 1 clears the flag.
- R8: If the output queue is full when a fill completes, overflow is set and that descriptor is discarded.
- R9: In mode 3, alignment falling during a fill abandons the slot: no descriptor is emitted and writing stops until the next multiframe start.
- R10: In modes 0, 1 and 2, a fill starts on any valid octet, with no boundary marker needed.
- R11: Clearing control bit 0 stops all writes and abandons a fill in progress without a descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Control register write strobe |
| csrWrData | input | 16 | Control word: bit 0 enable, bits 2:1 mode, bit 12 overflow clear |
| csrRdData | output | 16 | Status word |
| descWrEn | input | 1 | Push a free slot into the input queue |
| descWrSlot | input | 7 | Slot index to push |
| descRdEn | input | 1 | Pop the output queue head |
| descRdData | output | 16 | Output queue head, or 0 when empty |
| lineValid | input | 1 | Octet strobe |
| lineByte | input | 8 | Received octet |
| lineMfStart | input | 1 | Octet is the first of a multiframe |
| lineAligned | input | 1 | Alignment level from the upstream search |
| crcValid | input | 1 | CRC verdict strobe |
| crcSub | input | 1 | Half of the multiframe the verdict belongs to |
| crcOk | input | 1 | Verdict: 1 means CRC correct |
| ramWe | output | 1 | Data RAM write enable |
| ramAddr | output | 16 | Data RAM byte address |
| ramData | output | 8 | Data RAM write byte |

## Verification
The bench builds the engine with 4 frames of 8 timeslots, giving 32-octet multiframes and a 12-bit address, and keeps the queue depth at 4. The short multiframe lets the bench fill the output queue completely and push a completion past it. It also covers a fill from both empty queues, mid-fill loss of alignment and disable, and every CRC verdict pattern, all within a few thousand cycles. Every RAM write is compared against an address and byte computed from the slot and octet position.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int REG_W = 16;

  // control / status bit positions (fixed by the register map)
  localparam int CSR_EN      = 0;
  localparam int CSR_ALIGNED = 1;
  localparam int CSR_IN_MT   = 8;
  localparam int CSR_IN_FULL = 9;
  localparam int CSR_OUT_MT  = 10;
  localparam int CSR_OUT_FULL= 11;
  localparam int CSR_OVFL    = 12;

  // descriptor bit positions
  localparam int DESC_VALID = 15;
  localparam int DESC_CRC_B = 14;
  localparam int DESC_CRC_A = 13;

  typedef enum logic [1:0] {
    MODE_RAW    = 2'd0,
    MODE_OCTET  = 2'd1,
    MODE_FRAME  = 2'd2,
    MODE_MFRAME = 2'd3
  } rx_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeSlot;   // pop input queue, latch slot, restart position and CRC
    logic storeByte;  // write current octet, advance position
    logic emitDesc;   // push completed descriptor
  } rxd_strobe_t;

endpackage

// File: rtl/rxd_queue.sv
module rxd_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] headData,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign headData = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

endmodule

// File: rtl/rxd_datapath.sv
module rxd_datapath
  import rxd_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int SLOTS  = 32,
  parameter int IDX_W  = 7,
  parameter int QDEPTH = 4,
  localparam int POS_W  = $clog2(FRAMES * SLOTS),
  localparam int ADDR_W = IDX_W + POS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxd_strobe_t       strobe,
  input  logic [7:0]        lineByte,
  input  logic              crcValid,
  input  logic              crcSub,
  input  logic              crcOk,
  input  logic              descWrEn,
  input  logic [IDX_W-1:0]  descWrSlot,
  input  logic              descRdEn,
  output logic [REG_W-1:0]  descRdData,
  output logic              inEmpty,
  output logic              inFull,
  output logic              outEmpty,
  output logic              outFull,
  output logic              lastPos,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramData
);
  localparam int LAST = FRAMES * SLOTS - 1;

  logic [IDX_W-1:0] inHead, slotReg, slotNow;
  logic [POS_W-1:0] pos, posNow;
  logic [1:0]       crcFlags, crcNow;
  logic [REG_W-1:0] outHead, descDone;

  rxd_queue #(.DEPTH(QDEPTH), .W(IDX_W)) u_inQ (
    .clk(clk), .rstN(rstN),
    .push(descWrEn), .pushData(descWrSlot),
    .pop(strobe.takeSlot), .headData(inHead),
    .empty(inEmpty), .full(inFull)
  );

  rxd_queue #(.DEPTH(QDEPTH), .W(REG_W)) u_outQ (
    .clk(clk), .rstN(rstN),
    .push(strobe.emitDesc), .pushData(descDone),
    .pop(descRdEn), .headData(outHead),
    .empty(outEmpty), .full(outFull)
  );

  assign posNow  = strobe.takeSlot ? '0 : pos;
  assign slotNow = strobe.takeSlot ? inHead : slotReg;
  assign lastPos = (pos == POS_W'(LAST));

  always_comb begin
    crcNow = strobe.takeSlot ? 2'b00 : crcFlags;
    if (crcValid) crcNow[crcSub] = crcOk;
  end

  always_comb begin
    descDone = '0;
    descDone[DESC_VALID] = 1'b1;
    descDone[DESC_CRC_B] = crcNow[1];
    descDone[DESC_CRC_A] = crcNow[0];
    descDone[IDX_W-1:0]  = slotNow;
  end

  assign descRdData = outEmpty ? '0 : outHead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos      <= '0;
      slotReg  <= '0;
      crcFlags <= '0;
      ramWe    <= 1'b0;
      ramAddr  <= '0;
      ramData  <= '0;
    end else begin
      crcFlags <= crcNow;
      if (strobe.takeSlot)  slotReg <= inHead;
      if (strobe.storeByte) pos <= posNow + 1'b1;
      ramWe <= strobe.storeByte;
      if (strobe.storeByte) begin
        ramAddr <= {slotNow, posNow};
        ramData <= lineByte;
      end
    end
  end

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrWrEn,
  input  logic [REG_W-1:0] csrWrData,
  input  logic             lineValid,
  input  logic             lineMfStart,
  input  logic             lineAligned,
  input  logic             inEmpty,
  input  logic             outFull,
  input  logic             lastPos,
  output rxd_strobe_t      strobe,
  output logic             rxEnable,
  output rx_mode_e         rxMode,
  output logic             overflow
);
  typedef enum logic {ST_WAIT, ST_FILL} fill_state_e;

  fill_state_e state, nextState;
  logic setOvfl, mfaMode, startOk;

  assign mfaMode = (rxMode == MODE_MFRAME);
  assign startOk = lineValid && rxEnable && !overflow &&
                   (!mfaMode || (lineMfStart && lineAligned));

  always_comb begin
    strobe    = '0;
    setOvfl   = 1'b0;
    nextState = state;
    case (state)
      ST_WAIT: begin
        if (startOk) begin
          if (inEmpty) begin
            setOvfl = 1'b1;
          end else begin
            strobe.takeSlot  = 1'b1;
            strobe.storeByte = 1'b1;
            nextState        = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (!rxEnable || (mfaMode && !lineAligned)) begin
          nextState = ST_WAIT;
        end else if (lineValid) begin
          strobe.storeByte = 1'b1;
          if (lastPos) begin
            nextState = ST_WAIT;
            if (outFull) setOvfl = 1'b1;
            else         strobe.emitDesc = 1'b1;
          end
        end
      end
      default: nextState = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      rxEnable <= 1'b0;
      rxMode   <= MODE_RAW;
      overflow <= 1'b0;
    end else begin
      state <= nextState;
      if (csrWrEn) begin
        rxEnable <= csrWrData[CSR_EN];
        rxMode   <= rx_mode_e'(csrWrData[2:1]);
      end
      if (setOvfl)                            overflow <= 1'b1;
      else if (csrWrEn && csrWrData[CSR_OVFL]) overflow <= 1'b0;
    end
  end

endmodule

// File: rtl/e1_rx_desc_engine.sv
module e1_rx_desc_engine
  import rxd_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int SLOTS  = 32,
  parameter int IDX_W  = 7,
  parameter int QDEPTH = 4,
  localparam int POS_W  = $clog2(FRAMES * SLOTS),
  localparam int ADDR_W = IDX_W + POS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWrEn,
  input  logic [15:0]       csrWrData,
  output logic [15:0]       csrRdData,
  input  logic              descWrEn,
  input  logic [IDX_W-1:0]  descWrSlot,
  input  logic              descRdEn,
  output logic [15:0]       descRdData,
  input  logic              lineValid,
  input  logic [7:0]        lineByte,
  input  logic              lineMfStart,
  input  logic              lineAligned,
  input  logic              crcValid,
  input  logic              crcSub,
  input  logic              crcOk,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramData
);
  rxd_strobe_t strobe;
  rx_mode_e    rxMode;
  logic        rxEnable, overflow;
  logic        inEmpty, inFull, outEmpty, outFull, lastPos;

  rxd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .lineValid(lineValid), .lineMfStart(lineMfStart), .lineAligned(lineAligned),
    .inEmpty(inEmpty), .outFull(outFull), .lastPos(lastPos),
    .strobe(strobe), .rxEnable(rxEnable), .rxMode(rxMode), .overflow(overflow)
  );

  rxd_datapath #(.FRAMES(FRAMES), .SLOTS(SLOTS), .IDX_W(IDX_W), .QDEPTH(QDEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lineByte(lineByte),
    .crcValid(crcValid), .crcSub(crcSub), .crcOk(crcOk),
    .descWrEn(descWrEn), .descWrSlot(descWrSlot),
    .descRdEn(descRdEn), .descRdData(descRdData),
    .inEmpty(inEmpty), .inFull(inFull), .outEmpty(outEmpty), .outFull(outFull),
    .lastPos(lastPos),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData)
  );

  always_comb begin
    csrRdData = '0;
    csrRdData[CSR_EN]       = rxEnable;
    csrRdData[CSR_ALIGNED]  = lineAligned;
    csrRdData[CSR_IN_MT]    = inEmpty;
    csrRdData[CSR_IN_FULL]  = inFull;
    csrRdData[CSR_OUT_MT]   = outEmpty;
    csrRdData[CSR_OUT_FULL] = outFull;
    csrRdData[CSR_OVFL]     = overflow;
  end

endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int POS_W  = 9,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              csrWrEn,
  input logic [15:0]       csrWrData,
  input logic [15:0]       csrRdData,
  input logic [15:0]       descRdData,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr
);
  // R2: a queue is never reported empty and full at once
  assert_flag_pairs_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(csrRdData[8] && csrRdData[9]) && !(csrRdData[10] && csrRdData[11]));

  // R5: descriptor valid bit mirrors a non-empty output queue
  assert_rd_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    descRdData[15] == !csrRdData[10]);

  // R7: overflow stays set until a clearing write
  assert_ovfl_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    csrRdData[12] && !(csrWrEn && csrWrData[12]) |=> csrRdData[12]);

  // R7 / R11: a write only follows a cycle where reception was enabled and clean
  assert_write_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> $past(csrRdData[0] && !csrRdData[12]));

  // R4: back-to-back writes within a fill advance the address by one
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    ramWe && $past(ramWe) && (ramAddr[POS_W-1:0] != '0) |-> ramAddr == $past(ramAddr) + 1'b1);

endmodule

bind e1_rx_desc_engine rxd_checker #(.POS_W(POS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
  .csrRdData(csrRdData), .descRdData(descRdData), .ramWe(ramWe), .ramAddr(ramAddr)
);

// File: tb/sim_e1_rx_desc_engine.sv
module sim_e1_rx_desc_engine;
  localparam int CLK_PERIOD = 10;
  localparam int FRAMES = 4;
  localparam int SLOTS  = 8;
  localparam int IDX_W  = 7;
  localparam int MF_LEN = FRAMES * SLOTS;
  localparam int POS_W  = $clog2(MF_LEN);
  localparam int ADDR_W = IDX_W + POS_W;

  logic clk = 0, rstN = 0;
  logic csrWrEn = 0, descWrEn = 0, descRdEn = 0;
  logic [15:0] csrWrData = '0, csrRdData, descRdData;
  logic [IDX_W-1:0] descWrSlot = '0;
  logic lineValid = 0, lineMfStart = 0, lineAligned = 0;
  logic [7:0] lineByte = '0;
  logic crcValid = 0, crcSub = 0, crcOk = 0;
  logic ramWe;
  logic [ADDR_W-1:0] ramAddr;
  logic [7:0] ramData;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [ADDR_W+7:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_rx_desc_engine #(.FRAMES(FRAMES), .SLOTS(SLOTS), .IDX_W(IDX_W), .QDEPTH(4)) u0 (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .descWrEn(descWrEn), .descWrSlot(descWrSlot), .descRdEn(descRdEn), .descRdData(descRdData),
    .lineValid(lineValid), .lineByte(lineByte), .lineMfStart(lineMfStart), .lineAligned(lineAligned),
    .crcValid(crcValid), .crcSub(crcSub), .crcOk(crcOk),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // R4: every RAM write must match the next expected address/byte
  always @(negedge clk) begin
    if (rstN && ramWe) begin
      if (expQ.size() == 0) chk("R4 unexpected write", {ramAddr, ramData}, 32'hFFFF_FFFF);
      else chk("R4 write", {ramAddr, ramData}, expQ.pop_front());
    end
  end

  task automatic csrWrite(input logic [15:0] v);
    @(negedge clk); csrWrEn = 1; csrWrData = v;
    @(negedge clk); csrWrEn = 0;
  endtask

  task automatic pushSlot(input int s);
    @(negedge clk); descWrEn = 1; descWrSlot = IDX_W'(s);
    @(negedge clk); descWrEn = 0;
  endtask

  task automatic popDesc(input string req, input logic [15:0] exp);
    @(negedge clk); chk(req, descRdData, exp); descRdEn = 1;
    @(negedge clk); descRdEn = 0;
  endtask

  task automatic setAligned(input bit v);
    @(negedge clk); lineAligned = v;
  endtask

  task automatic status(input string req, input logic [15:0] mask, input logic [15:0] exp);
    @(negedge clk); chk(req, csrRdData & mask, exp);
  endtask

  // send n octets; crcMask bit h reports a verdict for half h, crcOkBits its result
  task automatic sendMf(input string req, input int slot, input int n, input bit withStart,
                        input bit expectWr, input int crcMask, input int crcOkBits);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lineValid   = 1;
      lineByte    = 8'((slot * 7 + i * 3) & 255);
      lineMfStart = withStart && (i == 0);
      crcValid    = 0;
      if (i == 3 && crcMask[0]) begin crcValid = 1; crcSub = 0; crcOk = crcOkBits[0]; end
      if (i == MF_LEN/2 + 4 && crcMask[1]) begin crcValid = 1; crcSub = 1; crcOk = crcOkBits[1]; end
      if (expectWr) expQ.push_back({ADDR_W'((slot << POS_W) | i), lineByte});
    end
    @(negedge clk);
    lineValid = 0; lineMfStart = 0; crcValid = 0;
    @(negedge clk);
    chk({req, " writes drained"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    status("R1 reset status", 16'hFFFF, 16'h0500);
    @(negedge clk); chk("R1 reset descriptor", descRdData, 16'h0000);

    // R2 fill input queue, fifth push ignored
    pushSlot(8'h03); pushSlot(8'h55); pushSlot(8'h7F); pushSlot(8'h10); pushSlot(8'h44);
    status("R2 input full", 16'h0300, 16'h0200);

    csrWrite(16'h0007);
    setAligned(1);
    status("R1 enabled and aligned", 16'h0003, 16'h0003);

    // R3 no start marker in mode 3: nothing written
    sendMf("R3", 0, 5, 0, 0, 0, 0);

    // R4/R5/R6 four multiframes with distinct CRC patterns
    sendMf("R4", 8'h03, MF_LEN, 1, 1, 3, 3);
    sendMf("R4", 8'h55, MF_LEN, 1, 1, 3, 2);
    sendMf("R4", 8'h7F, MF_LEN, 1, 1, 3, 1);
    sendMf("R6", 8'h10, MF_LEN, 1, 1, 0, 0);
    status("R2 fifth slot ignored, output full", 16'h0F00, 16'h0900);

    // R8 completion into a full output queue
    pushSlot(8'h20);
    sendMf("R8", 8'h20, MF_LEN, 1, 1, 3, 3);
    status("R8 overflow set", 16'h1000, 16'h1000);
    popDesc("R5 first descriptor", 16'hE003);
    popDesc("R6 second half ok only", 16'hC055);
    popDesc("R6 first half ok only", 16'hA07F);
    popDesc("R6 verdicts cleared at start", 16'h8010);
    @(negedge clk); chk("R8 descriptor discarded, queue empty", descRdData, 16'h0000);

    // R7 clear, then start with empty input queue
    csrWrite(16'h1007);
    status("R7 overflow cleared", 16'h1000, 16'h0000);
    sendMf("R7", 0, MF_LEN, 1, 0, 0, 0);
    status("R7 underflow sets overflow", 16'h1000, 16'h1000);
    pushSlot(8'h23);
    sendMf("R7", 8'h23, MF_LEN, 1, 0, 0, 0);
    status("R7 octets dropped, slot kept", 16'h1100, 16'h1000);
    csrWrite(16'h1007);
    status("R7 overflow cleared again", 16'h1000, 16'h0000);

    // R9 alignment loss mid-fill
    sendMf("R9", 8'h23, 10, 1, 1, 0, 0);
    setAligned(0);
    setAligned(1);
    sendMf("R9", 8'h23, 6, 0, 0, 0, 0);
    @(negedge clk); chk("R9 no descriptor", descRdData, 16'h0000);
    status("R9 slot consumed", 16'h1100, 16'h0100);
    pushSlot(8'h22);
    sendMf("R9", 8'h22, MF_LEN, 1, 1, 0, 0);
    popDesc("R9 restart at boundary", 16'h8022);

    // R10 byte-aligned mode needs no boundary marker
    csrWrite(16'h0003);
    pushSlot(8'h30);
    sendMf("R10", 8'h30, MF_LEN, 0, 1, 3, 3);
    popDesc("R10 descriptor", 16'hE030);

    // R11 disable mid-fill
    pushSlot(8'h31);
    sendMf("R11", 8'h31, 10, 0, 1, 0, 0);
    csrWrite(16'h0002);
    sendMf("R11", 8'h31, 6, 0, 0, 0, 0);
    status("R11 disabled", 16'h0001, 16'h0000);
    @(negedge clk); chk("R11 no descriptor", descRdData, 16'h0000);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule